// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives two clock enables for an audio serial port from one fast source clock. The source is divided by a cascade of counters: a fixed divide-by-2, then a prescaler that divides by 8 or passes through, then a modulus counter set from 1 to 256. The output of this cascade is the high-frequency clock enable. A last fine counter, set from 1 to 16, divides that enable again to give the bit clock enable. Both enables are one-cycle pulses in the source clock domain, and each has its own output polarity.

When the source is the external crystal, a bypass setting hands the source straight to the high-frequency enable, which is then active on every cycle. The bit clock then comes from the fine counter alone. Software picks the field values for a wanted ratio and writes them through a synchronous configuration port. A per-field select lets it change one field and leave the others as they are. Each write restarts the counters from zero, so the new ratio holds from the write onwards.

Top module: `audclk_div_chain`

## Requirements
- R1: After reset both enables are inactive. The defaults are prescale 1, modulus 1, fine 1, no bypass and polarity 0, which gives a period of 2 cycles on both enables.
- R2: Without bypass, the high-frequency enable has a period of 2 × P × M cycles, where M = `cfg_mod` + 1.
- R3: The prescale field `cfg_pre8` = 1 sets P = 8. A value of 0 sets P = 1.
- R4: The bit clock enable has a period equal to the high-frequency period times F, where F = `cfg_fine` + 1.
- R5: Every bit clock pulse falls in a cycle that also carries a high-frequency pulse.
- R6: With the bypass bit set and `src_ext` = 1, the high-frequency enable is active on every cycle and the bit clock period is F cycles.
- R7: With the bypass bit set and `src_ext` = 0, the bypass has no effect and the periods follow R2 and R4.
- R8: `cfg_fsel` picks the fields that a write updates: bit0 prescale, bit1 modulus, bit2 fine, bit3 bypass, bit4 high-frequency polarity, bit5 bit clock polarity. Fields whose select bit is clear keep their value.
- R9: In the cycle after a write, both enables are inactive. Counting the write edge as edge 0, the first pulse of an output with period N is seen after edge N.
- R10: A polarity bit of 1 inverts its output. That output then idles high and pulses low.
- R11: The largest setting (P = 8, M = 256, F = 16) gives a bit clock period of 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ext | input | 1 | 1 when the source is the external crystal, which enables the bypass |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fsel | input | 6 | Per-field write select, bit mapping as in R8 |
| cfg_pre8 | input | 1 | Prescale field: 1 selects divide-by-8 |
| cfg_mod | input | 8 | Modulus field, holds M − 1 |
| cfg_fine | input | 4 | Fine field, holds F − 1 |
| cfg_byp | input | 1 | Bypass field |
| cfg_hpol | input | 1 | High-frequency enable polarity |
| cfg_spol | input | 1 | Bit clock enable polarity |
| hck_en | output | 1 | High-frequency clock enable pulse |
| sck_en | output | 1 | Bit clock enable pulse |

## Verification
The assertions check four things on every cycle: bit clock pulses always coincide with high-frequency pulses, both outputs are inactive in the cycle after a write, a bypassed external source drives the high-frequency enable on every cycle, and without bypass no two high-frequency pulses are adjacent. They also check that the internal counters never pass their programmed terminal values. Only the bench scenarios can show the exact periods and products, because they count the cycles between pulses against 2·P·M and 2·P·M·F. The same holds for selective field writes, for bypass being ignored on a non-external source, for polarity inversion, and for the full 65536-cycle ratio.

// File: rtl/audclk_div_chain.sv
module audclk_div_chain #(
  parameter int MOD_W     = 8,
  parameter int FINE_W    = 4,
  parameter int PRE_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ext,
  input  logic              cfg_wr,
  input  logic [5:0]        cfg_fsel,
  input  logic              cfg_pre8,
  input  logic [MOD_W-1:0]  cfg_mod,
  input  logic [FINE_W-1:0] cfg_fine,
  input  logic              cfg_byp,
  input  logic              cfg_hpol,
  input  logic              cfg_spol,
  output logic              hck_en,
  output logic              sck_en
);
  localparam int PRE_W = $clog2(PRE_RATIO);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

  logic              pre8_r, byp_r, hpol_r, spol_r;
  logic [MOD_W-1:0]  mod_r, cm;
  logic [FINE_W-1:0] fine_r, cf;
  logic [PRE_W-1:0]  cp;
  logic              c2, hck_p, sck_p;

  logic byp_eff, t2, tp, tm, hck_tick, sck_tick;

  assign byp_eff  = byp_r & src_ext;
  assign t2       = c2;
  assign tp       = t2 & (~pre8_r | (cp == PRE_LAST));
  assign tm       = tp & (cm == mod_r);
  assign hck_tick = byp_eff | tm;
  assign sck_tick = hck_tick & (cf == fine_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre8_r <= 1'b0;
      mod_r  <= '0;
      fine_r <= '0;
      byp_r  <= 1'b0;
      hpol_r <= 1'b0;
      spol_r <= 1'b0;
      c2     <= 1'b0;
      cp     <= '0;
      cm     <= '0;
      cf     <= '0;
      hck_p  <= 1'b0;
      sck_p  <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_fsel[0]) pre8_r <= cfg_pre8;
      if (cfg_fsel[1]) mod_r  <= cfg_mod;
      if (cfg_fsel[2]) fine_r <= cfg_fine;
      if (cfg_fsel[3]) byp_r  <= cfg_byp;
      if (cfg_fsel[4]) hpol_r <= cfg_hpol;
      if (cfg_fsel[5]) spol_r <= cfg_spol;
      c2    <= 1'b0;
      cp    <= '0;
      cm    <= '0;
      cf    <= '0;
      hck_p <= 1'b0;
      sck_p <= 1'b0;
    end else begin
      c2 <= byp_eff ? 1'b0 : ~c2;
      if (!byp_eff && t2 && pre8_r)
        cp <= (cp == PRE_LAST) ? '0 : cp + 1'b1;
      if (!byp_eff && tp)
        cm <= tm ? '0 : cm + 1'b1;
      if (hck_tick)
        cf <= sck_tick ? '0 : cf + 1'b1;
      hck_p <= hck_tick;
      sck_p <= sck_tick;
    end
  end

  assign hck_en = hck_p ^ hpol_r;
  assign sck_en = sck_p ^ spol_r;
endmodule

module audclk_div_chain_chk #(
  parameter int MOD_W  = 8,
  parameter int FINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_ext,
  input logic              cfg_wr,
  input logic              hck_en,
  input logic              sck_en,
  input logic              hpol_r,
  input logic              spol_r,
  input logic              byp_r,
  input logic [MOD_W-1:0]  mod_r,
  input logic [MOD_W-1:0]  cm,
  input logic [FINE_W-1:0] fine_r,
  input logic [FINE_W-1:0] cf
);
  logic h_act, s_act;
  assign h_act = hck_en ^ hpol_r;
  assign s_act = sck_en ^ spol_r;

  a_r5_sck_within_hck: assert property (@(posedge clk) disable iff (!rst_n)
    s_act |-> h_act);

  a_r9_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!h_act && !s_act));

  a_r6_bypass_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_r && src_ext && !cfg_wr) |=> h_act);

  a_r2_no_adjacent_hck: assert property (@(posedge clk) disable iff (!rst_n)
    (h_act && !(byp_r && src_ext) && !cfg_wr) |=> !h_act);

  a_r2_mod_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cm <= mod_r);

  a_r4_fine_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cf <= fine_r);
endmodule

bind audclk_div_chain audclk_div_chain_chk #(.MOD_W(MOD_W), .FINE_W(FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .cfg_wr(cfg_wr),
  .hck_en(hck_en), .sck_en(sck_en), .hpol_r(hpol_r), .spol_r(spol_r),
  .byp_r(byp_r), .mod_r(mod_r), .cm(cm), .fine_r(fine_r), .cf(cf)
);

// File: tb/audclk_div_chain_test.sv
module audclk_div_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_ext = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [5:0] cfg_fsel = '0;
  logic       cfg_pre8 = 1'b0;
  logic [7:0] cfg_mod = '0;
  logic [3:0] cfg_fine = '0;
  logic       cfg_byp = 1'b0;
  logic       cfg_hpol = 1'b0;
  logic       cfg_spol = 1'b0;
  logic       hck_en, sck_en;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic exp_hp = 1'b0;
  logic exp_sp = 1'b0;

  audclk_div_chain uut (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .cfg_wr(cfg_wr),
    .cfg_fsel(cfg_fsel), .cfg_pre8(cfg_pre8), .cfg_mod(cfg_mod),
    .cfg_fine(cfg_fine), .cfg_byp(cfg_byp), .cfg_hpol(cfg_hpol),
    .cfg_spol(cfg_spol), .hck_en(hck_en), .sck_en(sck_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<%0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] sel, input logic pre, input logic [7:0] m,
                    input logic [3:0] f, input logic b, input logic hp, input logic sp);
    cfg_fsel = sel; cfg_pre8 = pre; cfg_mod = m; cfg_fine = f;
    cfg_byp = b; cfg_hpol = hp; cfg_spol = sp; cfg_wr = 1'b1;
    if (sel[4]) exp_hp = hp;
    if (sel[5]) exp_sp = sp;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(hck_en == exp_hp && sck_en == exp_sp, "R9 quiet after write",
        {hck_en, sck_en}, {exp_hp, exp_sp});
  endtask

  task automatic meas(input int nh, input int ns, input bit sck_twice, input string tag);
    int th1 = 0, th2 = 0, ts1 = 0, ts2 = 0, n = 0;
    bit coinc_ok = 1'b1;
    while (n < 70000 && !(th2 != 0 && ts1 != 0 && (!sck_twice || ts2 != 0))) begin
      @(negedge clk);
      n++;
      if (hck_en ^ exp_hp) begin
        if (th1 == 0) th1 = n; else if (th2 == 0) th2 = n;
      end
      if (sck_en ^ exp_sp) begin
        if (!(hck_en ^ exp_hp)) coinc_ok = 1'b0;
        if (ts1 == 0) ts1 = n; else if (ts2 == 0) ts2 = n;
      end
    end
    chk(th1 == nh, {tag, " hck first"}, th1, nh);
    chk(th2 - th1 == nh, {tag, " hck period"}, th2 - th1, nh);
    chk(ts1 == ns, {tag, " sck first"}, ts1, ns);
    if (sck_twice) chk(ts2 - ts1 == ns, {tag, " sck period"}, ts2 - ts1, ns);
    chk(coinc_ok, "R5 sck within hck", coinc_ok, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(hck_en == 1'b0 && sck_en == 1'b0, "R1 reset idle", {hck_en, sck_en}, 0);
    rst_n = 1'b1;
    meas(2, 2, 1'b1, "R1 defaults");
  endtask

  task automatic t_modulus;
    wr(6'h3f, 1'b0, 8'd4, 4'd2, 1'b0, 1'b0, 1'b0);
    meas(10, 30, 1'b1, "R2 R4 P1 M5 F3");
  endtask

  task automatic t_prescale;
    wr(6'h3f, 1'b1, 8'd2, 4'd0, 1'b0, 1'b0, 1'b0);
    meas(48, 48, 1'b1, "R3 P8 M3 F1");
  endtask

  task automatic t_bypass;
    src_ext = 1'b1;
    wr(6'h3f, 1'b0, 8'd9, 4'd3, 1'b1, 1'b0, 1'b0);
    meas(1, 4, 1'b1, "R6 bypass F4");
  endtask

  task automatic t_bypass_ignored;
    src_ext = 1'b0;
    wr(6'h3f, 1'b0, 8'd1, 4'd1, 1'b1, 1'b0, 1'b0);
    meas(4, 8, 1'b1, "R7 bypass ignored");
  endtask

  task automatic t_select;
    wr(6'h3f, 1'b0, 8'd3, 4'd0, 1'b0, 1'b0, 1'b0);
    wr(6'b000100, 1'b1, 8'd0, 4'd2, 1'b1, 1'b1, 1'b1);
    meas(8, 24, 1'b1, "R8 fine only");
  endtask

  task automatic t_polarity;
    wr(6'h3f, 1'b0, 8'd1, 4'd1, 1'b0, 1'b1, 1'b1);
    chk(hck_en == 1'b1 && sck_en == 1'b1, "R10 idle high", {hck_en, sck_en}, 3);
    meas(4, 8, 1'b1, "R10 inverted");
    wr(6'b110000, 1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_restart;
    wr(6'h3f, 1'b0, 8'd9, 4'd0, 1'b0, 1'b0, 1'b0);
    repeat (7) @(negedge clk);
    wr(6'h3f, 1'b0, 8'd9, 4'd0, 1'b0, 1'b0, 1'b0);
    meas(20, 20, 1'b1, "R9 restart");
  endtask

  task automatic t_max;
    wr(6'h3f, 1'b1, 8'd255, 4'd15, 1'b0, 1'b0, 1'b0);
    meas(4096, 65536, 1'b0, "R11 max ratio");
  endtask

  initial begin
    t_reset;
    t_modulus;
    t_prescale;
    t_bypass;
    t_bypass_ignored;
    t_select;
    t_polarity;
    t_restart;
    t_max;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule